// File: doc/BRIEF.md
# Coalescing Write-Through Store Buffer

This block sits between a write-through first-level data cache and the next level of the memory hierarchy. The next level cannot take one write per store. Every store the cache lets through enters a small set of line-sized entries. A store whose line is already held merges into that entry, so a run of stores to neighbouring words leaves the block as a single line write.

Each entry holds a line tag, a full line of data and a per-byte written mask. Entries leave oldest-first through a valid/ready drain port. Each transfer carries the tag, the line data and the byte mask, and the next level updates only the masked bytes. When every entry is in use and a store matches none of them, the block holds off the store with a stall output until an entry frees.

The store side takes a word address, a word of data and per-byte enables. A store is accepted in any cycle where it is valid and the stall output is low.

Top module: `coalescing_store_buffer`

## Requirements
- R1: After reset, no entry is held: `dr_valid` is low, and `st_stall` is low.
- R2: An accepted store to a line held by no usable entry allocates a new entry. The line tag is the word address with its two low bits removed, and those two bits select word w of the line. Enabled store byte k lands in line byte 4*w+k, which is `dr_data` bits [8*(4*w+k)+7 : 8*(4*w+k)]. Bytes that were never written drain as zero.
- R3: An accepted store whose tag matches a held entry that is not draining in that cycle merges into that entry. Only its enabled bytes change, and no new entry is taken.
- R4: `dr_mask` bit b is set exactly when line byte b was written by at least one store merged into the entry.
- R5: Entries drain in allocation order, one line per cycle in which `dr_valid` and `dr_ready` are both high.
- R6: A store matching the entry that transfers in the same cycle does not join that transfer. It allocates a new entry, which drains afterwards.
- R7: `st_stall` is high exactly when `st_valid` is high, all entries are held and the store matches no usable entry. This includes the cycle in which the head drains. A stalled store is not taken.
- R8: With all entries held, a store that matches a usable entry is accepted without stall.
- R9: A merge into one entry and a drain transfer of another entry in the same cycle both take effect.
- R10: Every accepted store byte reaches the drain port exactly once, and the number of held entries never exceeds the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_waddr | input | 30 | Store word address |
| st_data | input | 32 | Store data word |
| st_be | input | 4 | Store byte enables |
| st_stall | output | 1 | Store cannot be accepted this cycle |
| dr_valid | output | 1 | Oldest entry presented for draining |
| dr_ready | input | 1 | Next level takes the presented line |
| dr_line | output | 28 | Line tag of the presented entry |
| dr_data | output | 128 | Line data of the presented entry |
| dr_mask | output | 16 | Written-byte mask of the presented entry |

## Verification
The bench checks a store that hits the line transferring in the same cycle. A design that merged into it would lose those bytes, and the bench would see a missing second line. It also checks a merge into a younger entry while the head drains, which a design with a shared update path would drop. It fills every entry and then sends both a matching and a non-matching store. A wrong full test would either overwrite an entry or stall a store that could have merged. Partial byte enables at several word offsets expose a shifted lane mapping or a mask that records whole words.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int SB_ADDR_W     = 32;
    localparam int SB_WORD_BYTES = 4;
    localparam int SB_LINE_BYTES = 16;
    localparam int SB_DEPTH      = 4;

    localparam int SB_WORD_W = SB_WORD_BYTES * 8;
    localparam int SB_LINE_W = SB_LINE_BYTES * 8;
    localparam int SB_BSEL_W = $clog2(SB_WORD_BYTES);
    localparam int SB_OFF_W  = $clog2(SB_LINE_BYTES);
    localparam int SB_WSEL_W = SB_OFF_W - SB_BSEL_W;
    localparam int SB_WA_W   = SB_ADDR_W - SB_BSEL_W;
    localparam int SB_TAG_W  = SB_ADDR_W - SB_OFF_W;

    typedef logic [SB_TAG_W-1:0]      tag_t;
    typedef logic [SB_WSEL_W-1:0]     wsel_t;
    typedef logic [SB_LINE_W-1:0]     line_t;
    typedef logic [SB_LINE_BYTES-1:0] bmask_t;

    typedef struct packed {
        logic   held;
        tag_t   tag;
        line_t  data;
        bmask_t mask;
    } slot_t;

    function automatic tag_t wa_tag(input logic [SB_WA_W-1:0] wa);
        return wa[SB_WA_W-1:SB_WSEL_W];
    endfunction

    function automatic wsel_t wa_word(input logic [SB_WA_W-1:0] wa);
        return wa[SB_WSEL_W-1:0];
    endfunction
endpackage

// File: rtl/sb_match.sv
module sb_match #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 28
) (
    input  logic [TAG_W-1:0]            probe,
    input  logic [DEPTH-1:0][TAG_W-1:0] tags,
    input  logic [DEPTH-1:0]            held,
    input  logic [DEPTH-1:0]            locked,
    output logic [DEPTH-1:0]            hit,
    output logic                        any_hit
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit[i] = held[i] && !locked[i] && (tags[i] == probe);
    end
    assign any_hit = |hit;
endmodule

// File: rtl/sb_merge.sv
module sb_merge #(
    parameter int LINE_BYTES = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic [LINE_BYTES*8-1:0]                       base_data,
    input  logic [LINE_BYTES-1:0]                         base_mask,
    input  logic [$clog2(LINE_BYTES/WORD_BYTES)-1:0]      wsel,
    input  logic [WORD_BYTES*8-1:0]                       wdata,
    input  logic [WORD_BYTES-1:0]                         wbe,
    output logic [LINE_BYTES*8-1:0]                       new_data,
    output logic [LINE_BYTES-1:0]                         new_mask
);
    localparam int WSEL_W = $clog2(LINE_BYTES / WORD_BYTES);

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        localparam int W = b / WORD_BYTES;
        localparam int K = b % WORD_BYTES;
        logic en;
        assign en = (wsel == WSEL_W'(W)) && wbe[K];
        assign new_data[8*b +: 8] = en ? wdata[8*K +: 8] : base_data[8*b +: 8];
        assign new_mask[b]        = base_mask[b] | en;
    end
endmodule

// File: rtl/coalescing_store_buffer.sv
module coalescing_store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = SB_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 st_valid,
    input  logic [SB_WA_W-1:0]   st_waddr,
    input  logic [SB_WORD_W-1:0] st_data,
    input  logic [SB_WORD_BYTES-1:0] st_be,
    output logic                 st_stall,
    output logic                 dr_valid,
    input  logic                 dr_ready,
    output logic [SB_TAG_W-1:0]  dr_line,
    output logic [SB_LINE_W-1:0] dr_data,
    output logic [SB_LINE_BYTES-1:0] dr_mask
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = IDX_W + 1;
    localparam logic [OCC_W-1:0] FULL_CNT = OCC_W'(DEPTH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    slot_t            slot_q [DEPTH];
    logic [IDX_W-1:0] head_q, tail_q;
    logic [OCC_W-1:0] occ_q;

    logic [DEPTH-1:0][SB_TAG_W-1:0] tag_vec;
    logic [DEPTH-1:0] held_vec, lock_vec, hit_vec;
    logic             any_hit;
    logic [IDX_W-1:0] hit_idx;
    logic             full, dr_fire, merge_fire, alloc_fire;
    line_t            base_data, upd_data;
    bmask_t           base_mask, upd_mask;
    tag_t             st_tag;

    function automatic logic [IDX_W-1:0] ptr_next(input logic [IDX_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign st_tag   = wa_tag(st_waddr);
    assign full     = (occ_q == FULL_CNT);
    assign dr_valid = (occ_q != '0);
    assign dr_fire  = dr_valid && dr_ready;

    for (genvar i = 0; i < DEPTH; i++) begin : g_vec
        assign tag_vec[i]  = slot_q[i].tag;
        assign held_vec[i] = slot_q[i].held;
        assign lock_vec[i] = dr_fire && (head_q == IDX_W'(i));
    end

    sb_match #(.DEPTH(DEPTH), .TAG_W(SB_TAG_W)) u_match (
        .probe   (st_tag),
        .tags    (tag_vec),
        .held    (held_vec),
        .locked  (lock_vec),
        .hit     (hit_vec),
        .any_hit (any_hit)
    );

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign base_data = any_hit ? slot_q[hit_idx].data : '0;
    assign base_mask = any_hit ? slot_q[hit_idx].mask : '0;

    sb_merge #(.LINE_BYTES(SB_LINE_BYTES), .WORD_BYTES(SB_WORD_BYTES)) u_merge (
        .base_data (base_data),
        .base_mask (base_mask),
        .wsel      (wa_word(st_waddr)),
        .wdata     (st_data),
        .wbe       (st_be),
        .new_data  (upd_data),
        .new_mask  (upd_mask)
    );

    assign st_stall   = st_valid && !any_hit && full;
    assign merge_fire = st_valid && any_hit;
    assign alloc_fire = st_valid && !any_hit && !full;

    assign dr_line = slot_q[head_q].tag;
    assign dr_data = slot_q[head_q].data;
    assign dr_mask = slot_q[head_q].mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            if (dr_fire) begin
                slot_q[head_q].held <= 1'b0;
                head_q <= ptr_next(head_q);
            end
            if (merge_fire) begin
                slot_q[hit_idx].data <= upd_data;
                slot_q[hit_idx].mask <= upd_mask;
            end
            if (alloc_fire) begin
                slot_q[tail_q] <= '{held: 1'b1, tag: st_tag, data: upd_data, mask: upd_mask};
                tail_q <= ptr_next(tail_q);
            end
            case ({alloc_fire, dr_fire})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int DEPTH = 4,
    parameter int OCC_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             st_valid,
    input logic             st_stall,
    input logic             dr_valid,
    input logic             dr_ready,
    input logic [OCC_W-1:0] occ,
    input logic             merge_fire,
    input logic             alloc_fire,
    input logic [DEPTH-1:0] hit_vec
);
    logic dr_fire;
    assign dr_fire = dr_valid && dr_ready;

    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> !dr_valid);

    p_one_target_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    p_merge_or_alloc_r3: assert property (@(posedge clk) disable iff (rst)
        !(merge_fire && alloc_fire));

    p_occ_track_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (int'(occ) == int'($past(occ)) + int'($past(alloc_fire)) - int'($past(dr_fire))));

    p_stall_cause_r7: assert property (@(posedge clk) disable iff (rst)
        st_stall |-> (st_valid && int'(occ) == DEPTH));

    p_stall_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        st_stall |-> (!merge_fire && !alloc_fire));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        int'(occ) <= DEPTH);
endmodule

bind coalescing_store_buffer sb_checker #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .st_valid   (st_valid),
    .st_stall   (st_stall),
    .dr_valid   (dr_valid),
    .dr_ready   (dr_ready),
    .occ        (occ_q),
    .merge_fire (merge_fire),
    .alloc_fire (alloc_fire),
    .hit_vec    (hit_vec)
);

// File: tb/coalescing_store_buffer_test.sv
module coalescing_store_buffer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NSTORE = 7;
    localparam int NDRAIN = 3;

    localparam logic [31:0] TB_ADDR [NSTORE] = '{32'h100, 32'h104, 32'h10C, 32'h200, 32'h100, 32'h308, 32'h20C};
    localparam logic [31:0] TB_DATA [NSTORE] = '{32'h11111111, 32'h22222222, 32'hAABBCCDD, 32'h33333333,
                                                  32'h44444444, 32'h55555555, 32'h66666666};
    localparam logic [3:0]  TB_BE   [NSTORE] = '{4'hF, 4'hF, 4'h3, 4'hF, 4'h4, 4'hC, 4'hF};

    localparam logic [27:0]  EX_LINE [NDRAIN] = '{28'h10, 28'h20, 28'h30};
    localparam logic [127:0] EX_DATA [NDRAIN] = '{
        128'h0000CCDD_00000000_22222222_11441111,
        128'h66666666_00000000_00000000_33333333,
        128'h00000000_55550000_00000000_00000000};
    localparam logic [15:0]  EX_MASK [NDRAIN] = '{16'h30FF, 16'hF00F, 16'h0C00};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         st_valid = 1'b0;
    logic [29:0]  st_waddr = '0;
    logic [31:0]  st_data = '0;
    logic [3:0]   st_be = '0;
    logic         st_stall;
    logic         dr_valid;
    logic         dr_ready = 1'b0;
    logic [27:0]  dr_line;
    logic [127:0] dr_data;
    logic [15:0]  dr_mask;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coalescing_store_buffer uut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_waddr(st_waddr), .st_data(st_data), .st_be(st_be),
        .st_stall(st_stall),
        .dr_valid(dr_valid), .dr_ready(dr_ready),
        .dr_line(dr_line), .dr_data(dr_data), .dr_mask(dr_mask)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] baddr, input logic [31:0] d,
                         input logic [3:0] be, input logic rdy);
        @(negedge clk);
        st_valid = v;
        st_waddr = baddr[31:2];
        st_data  = d;
        st_be    = be;
        dr_ready = rdy;
        #1;
    endtask

    task automatic expect_line(input string req, input logic [27:0] ln,
                               input logic [127:0] d, input logic [15:0] m);
        chk({req, " valid"}, 128'(dr_valid), 128'(1'b1));
        chk({req, " line"},  128'(dr_line), 128'(ln));
        chk({req, " data"},  dr_data, d);
        chk({req, " mask"},  128'(dr_mask), 128'(m));
    endtask

    task automatic drain_one(input string req, input logic [27:0] ln,
                             input logic [127:0] d, input logic [15:0] m);
        drive(1'b0, 32'h0, 32'h0, 4'h0, 1'b1);
        expect_line(req, ln, d, m);
        @(posedge clk);
    endtask

    task automatic expect_empty(input string req);
        drive(1'b0, 32'h0, 32'h0, 4'h0, 1'b0);
        chk({req, " empty"}, 128'(dr_valid), 128'(1'b0));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: idle after reset
        chk("R1 dr_valid", 128'(dr_valid), 128'(1'b0));
        chk("R1 st_stall", 128'(st_stall), 128'(1'b0));

        // Table: allocations (R2) and merges into held lines (R3, R4), no drain
        for (int i = 0; i < NSTORE; i++) begin
            drive(1'b1, TB_ADDR[i], TB_DATA[i], TB_BE[i], 1'b0);
            chk("R2/R3 no stall", 128'(st_stall), 128'(1'b0));
            @(posedge clk);
        end
        // R5, R4, R2: drained in order with merged bytes and masks
        for (int i = 0; i < NDRAIN; i++) begin
            drain_one("R5 table", EX_LINE[i], EX_DATA[i], EX_MASK[i]);
        end
        expect_empty("R10 table");

        // Fill all entries
        for (int i = 0; i < 4; i++) begin
            drive(1'b1, 32'h400 + 32'(i) * 32'h10, {4{8'h40 + 8'(i)}}, 4'hF, 1'b0);
            @(posedge clk);
        end
        // R7: no stall without a store
        drive(1'b0, 32'h500, 32'h50505050, 4'hF, 1'b0);
        chk("R7 idle no stall", 128'(st_stall), 128'(1'b0));
        // R7: full and no match -> stall
        drive(1'b1, 32'h500, 32'h50505050, 4'hF, 1'b0);
        chk("R7 full stall", 128'(st_stall), 128'(1'b1));
        @(posedge clk);
        // R8: full but matching -> accepted
        drive(1'b1, 32'h414, 32'h00000077, 4'h1, 1'b0);
        chk("R8 match no stall", 128'(st_stall), 128'(1'b0));
        @(posedge clk);
        // R7: still stalled in the cycle the head drains
        drive(1'b1, 32'h500, 32'h50505050, 4'hF, 1'b1);
        chk("R7 stall while draining", 128'(st_stall), 128'(1'b1));
        expect_line("R5 first", 28'h40, {96'h0, 32'h40404040}, 16'h000F);
        @(posedge clk);
        drive(1'b1, 32'h500, 32'h50505050, 4'hF, 1'b0);
        chk("R7 released", 128'(st_stall), 128'(1'b0));
        @(posedge clk);
        drain_one("R8 merged", 28'h41, {64'h0, 32'h00000077, 32'h41414141}, 16'h001F);
        drain_one("R5 third", 28'h42, {96'h0, 32'h42424242}, 16'h000F);
        drain_one("R5 fourth", 28'h43, {96'h0, 32'h43434343}, 16'h000F);
        drain_one("R10 stalled store", 28'h50, {96'h0, 32'h50505050}, 16'h000F);
        expect_empty("R10 fill");

        // R6: store to the line transferring now goes to a new entry
        drive(1'b1, 32'h600, 32'h60606060, 4'hF, 1'b0);
        @(posedge clk);
        drive(1'b1, 32'h604, 32'h61616161, 4'hF, 1'b1);
        chk("R6 no stall", 128'(st_stall), 128'(1'b0));
        expect_line("R6 head", 28'h60, {96'h0, 32'h60606060}, 16'h000F);
        @(posedge clk);
        drain_one("R6 new entry", 28'h60, {64'h0, 32'h61616161, 32'h0}, 16'h00F0);
        expect_empty("R6");

        // R9: merge into younger entry while head drains
        drive(1'b1, 32'h700, 32'h70707070, 4'hF, 1'b0);
        @(posedge clk);
        drive(1'b1, 32'h800, 32'h80808080, 4'hF, 1'b0);
        @(posedge clk);
        drive(1'b1, 32'h804, 32'h81818181, 4'hF, 1'b1);
        expect_line("R9 head", 28'h70, {96'h0, 32'h70707070}, 16'h000F);
        @(posedge clk);
        drain_one("R9 merged", 28'h80, {64'h0, 32'h81818181, 32'h80808080}, 16'h00FF);
        expect_empty("R9");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule